// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small memory-mapped register file for a processor evaluation board. A 32-bit register bus reaches it with a byte address, a write strobe, write data, a read strobe and read data. The address is decoded across a 64 KiB window. Software can read a fixed build-date identifier and the processor clock rate, set and read back a bank of LED outputs, and read the DIP switches. The switches are sampled through a two-stage synchronizer.

A dedicated write-only location works as a board reset trigger. Writing one exact 32-bit key to it produces a one-cycle request pulse. A separate reset controller acts on that pulse. Read data is registered and returns one cycle after the read strobe.

Top module: `board_ctrl_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the LED register, the switch synchronizer, `rd_data` and `board_rst_req` all clear to zero.
- R2: A read of byte offset 0x00 returns the constant 0x09272011.
- R3: A read of byte offset 0x04 returns the `CLK_HZ` parameter. Its default is 10,000,000 (0x00989680).
- R4: A write to offset 0x08 stores `wr_data[LED_W-1:0]` (1 = lit) and drives it on `led_out` from the following cycle. A read of 0x08 returns the stored value zero-extended. A read and a write to 0x08 in the same cycle return the value held before that write.
- R5: A read of offset 0x0C returns `dip_in` (1 = on), zero-extended, after two register stages. A change on `dip_in` before edge k is returned by a read sampled at edge k+2. A read sampled at edge k+1 still returns the old value.
- R6: A write of exactly 0x0000DEAD to offset 0x10 makes `board_rst_req` high for the single cycle after that write edge. Any other data value written there causes no pulse.
- R7: A read of any other 16-bit offset returns zero. This includes 0x10, unaligned offsets, and offsets that match a register only in the low bits, such as 0x1008.
- R8: Writes to offsets other than 0x08 and 0x10 change neither `led_out` nor `board_rst_req`.
- R9: `rd_data` is registered. It carries the addressed value in the cycle after a read strobe and is zero in a cycle that follows no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte offset inside the 64 KiB window |
| bus_wr | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| dip_in | input | SW_W (8) | Raw DIP switch levels |
| led_out | output | LED_W (8) | LED drive, 1 = lit |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
The bench compares the block against a behavioural model on every clock. It reads each register with and without an intervening write, which separates the constant sources from the LED storage. It sets the read and write strobes in the same cycle to check that a read returns the value from before the write.

The switch inputs change and are then read at one and two cycles of delay, which pins down the synchronizer depth. Near-miss keys, a correct key at an aliased offset, and writes to the read-only offsets separate the exact key and address match from a partial decode.

// File: rtl/brd_regs_pkg.sv
package brd_regs_pkg;
  localparam int unsigned BUS_AW = 16;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFF_ID   = 16'h0000;
  localparam logic [BUS_AW-1:0] OFF_FREQ = 16'h0004;
  localparam logic [BUS_AW-1:0] OFF_LED  = 16'h0008;
  localparam logic [BUS_AW-1:0] OFF_SW   = 16'h000C;
  localparam logic [BUS_AW-1:0] OFF_KICK = 16'h0010;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_ID   = 3'd1,
    SEL_FREQ = 3'd2,
    SEL_LED  = 3'd3,
    SEL_SW   = 3'd4,
    SEL_KICK = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/brd_sync.sv
module brd_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/brd_reg_decode.sv
module brd_reg_decode
  import brd_regs_pkg::*;
#(
  parameter int unsigned AW = BUS_AW
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    unique case (addr)
      OFF_ID:   sel = SEL_ID;
      OFF_FREQ: sel = SEL_FREQ;
      OFF_LED:  sel = SEL_LED;
      OFF_SW:   sel = SEL_SW;
      OFF_KICK: sel = SEL_KICK;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/brd_rst_key.sv
module brd_rst_key #(
  parameter int unsigned DW  = 32,
  parameter logic [DW-1:0] KEY = 32'h0000DEAD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [DW-1:0] data,
  output logic          req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= hit && (data == KEY);
  end

  // R6: a pulse only follows a keyed write to the trigger location
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(hit) && ($past(data) == KEY));
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import brd_regs_pkg::*;
#(
  parameter int unsigned LED_W    = 8,
  parameter int unsigned SW_W     = 8,
  parameter int unsigned SYNC_N   = 2,
  parameter logic [31:0] CLK_HZ   = 32'd10_000_000,
  parameter logic [31:0] BUILD_ID = 32'h09272011,
  parameter logic [31:0] KICK_KEY = 32'h0000DEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       wr_data,
  input  logic              bus_rd,
  output logic [31:0]       rd_data,
  input  logic [SW_W-1:0]   dip_in,
  output logic [LED_W-1:0]  led_out,
  output logic              board_rst_req
);
  reg_sel_e              sel;
  logic [LED_W-1:0]      led_q;
  logic [SW_W-1:0]       sw_q;
  logic [BUS_DW-1:0]     led_ext, sw_ext, rd_next;

  brd_reg_decode #(.AW(BUS_AW)) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  brd_sync #(.W(SW_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (dip_in),
    .q  (sw_q)
  );

  brd_rst_key #(.DW(BUS_DW), .KEY(KICK_KEY)) u_key (
    .clk (clk),
    .rst (rst),
    .hit (bus_wr && (sel == SEL_KICK)),
    .data(wr_data),
    .req (board_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst)                            led_q <= '0;
    else if (bus_wr && sel == SEL_LED)  led_q <= wr_data[LED_W-1:0];
  end
  assign led_out = led_q;

  always_comb begin
    led_ext = '0;
    led_ext[LED_W-1:0] = led_q;
    sw_ext = '0;
    sw_ext[SW_W-1:0] = sw_q;
  end

  always_comb begin
    unique case (sel)
      SEL_ID:   rd_next = BUILD_ID;
      SEL_FREQ: rd_next = CLK_HZ;
      SEL_LED:  rd_next = led_ext;
      SEL_SW:   rd_next = sw_ext;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) rd_data <= '0;
    else                rd_data <= rd_next;
  end

  // R9: no read strobe, no data
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> rd_data == '0);
  // R2: identifier location
  a_r2_build_id: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd) && $past(bus_addr) == OFF_ID |-> rd_data == BUILD_ID);
  // R7: unmapped location reads zero
  a_r7_hole_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd) && $past(sel) == SEL_NONE |-> rd_data == '0);
  // R8: LEDs hold unless their location is written
  a_r8_led_hold: assert property (@(posedge clk) disable iff (rst)
    !($past(bus_wr) && $past(bus_addr) == OFF_LED) |-> $stable(led_out));
endmodule

// File: tb/tb_board_ctrl_regs.sv
module tb_board_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  dip_in = '0;
  logic [7:0]  led_out;
  logic        board_rst_req;

  always #5 clk = ~clk;

  board_ctrl_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .wr_data(wr_data), .bus_rd(bus_rd), .rd_data(rd_data),
    .dip_in(dip_in), .led_out(led_out), .board_rst_req(board_rst_req)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R9";

  // behavioural model state
  logic [7:0]  m_led = '0;
  logic [7:0]  m_s1 = '0, m_s2 = '0;
  logic [31:0] m_rd = '0;
  logic        m_req = 1'b0;

  function automatic logic [31:0] m_look(logic [15:0] a);
    case (a)
      16'h0000: return 32'h09272011;
      16'h0004: return 32'd10_000_000;
      16'h0008: return {24'd0, m_led};
      16'h000C: return {24'd0, m_s2};
      default:  return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [31:0] nrd;
    logic        nreq;
    @(posedge clk);
    if (rst) begin
      m_led = '0; m_s1 = '0; m_s2 = '0; m_rd = '0; m_req = 1'b0;
    end else begin
      nrd  = bus_rd ? m_look(bus_addr) : 32'd0;
      nreq = bus_wr && bus_addr == 16'h0010 && wr_data == 32'h0000DEAD;
      if (bus_wr && bus_addr == 16'h0008) m_led = wr_data[7:0];
      m_s2 = m_s1;
      m_s1 = dip_in;
      m_rd = nrd;
      m_req = nreq;
    end
    @(negedge clk);
    chk({cur_req, " rd_data"}, rd_data, m_rd);
    chk("R4 led_out", {24'd0, led_out}, {24'd0, m_led});
    chk("R6 board_rst_req", {31'd0, board_rst_req}, {31'd0, m_req});
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    bus_addr = a; wr_data = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a);
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    dip_in = 8'hFF;
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 16'h0008; wr_data = 32'hFF;
    repeat (3) step();
    bus_rd = 1'b0; bus_wr = 1'b0; dip_in = 8'h00;
    chk("R1 reset led", {24'd0, led_out}, 32'd0);
    chk("R1 reset rd", rd_data, 32'd0);
    chk("R1 reset req", {31'd0, board_rst_req}, 32'd0);
    rst = 1'b0;
    step(); step();
    cur_req = "R1";
    rd(16'h000C); chk("R1 sync cleared", rd_data, 32'd0);

    cur_req = "R2"; rd(16'h0000); chk("R2 id", rd_data, 32'h09272011);
    cur_req = "R3"; rd(16'h0004); chk("R3 freq", rd_data, 32'h00989680);
    cur_req = "R9"; step(); chk("R9 idle", rd_data, 32'd0);

    cur_req = "R4";
    rd(16'h0008); chk("R4 led reset read", rd_data, 32'd0);
    wr(16'h0008, 32'hFFFF_FF5A); chk("R4 led drive", {24'd0, led_out}, 32'h5A);
    rd(16'h0008); chk("R4 led read", rd_data, 32'h5A);
    bus_rd = 1'b1; wr(16'h0008, 32'h0000_00C3); bus_rd = 1'b0;
    chk("R4 read old on same-cycle write", rd_data, 32'h5A);
    rd(16'h0008); chk("R4 led new", rd_data, 32'hC3);

    cur_req = "R5";
    dip_in = 8'hA5; step();
    rd(16'h000C); chk("R5 one stage not yet", rd_data, 32'd0);
    rd(16'h000C); chk("R5 two stages", rd_data, 32'hA5);
    dip_in = 8'h3C; step(); step();
    rd(16'h000C); chk("R5 later change", rd_data, 32'h3C);

    cur_req = "R6";
    wr(16'h0010, 32'h0000DEAD); chk("R6 pulse", {31'd0, board_rst_req}, 32'd1);
    step(); chk("R6 single cycle", {31'd0, board_rst_req}, 32'd0);
    wr(16'h0010, 32'h0000DEAE); chk("R6 near key", {31'd0, board_rst_req}, 32'd0);
    wr(16'h0010, 32'h0001DEAD); chk("R6 upper bits", {31'd0, board_rst_req}, 32'd0);

    cur_req = "R7";
    rd(16'h0010); chk("R7 trigger reads zero", rd_data, 32'd0);
    rd(16'h000A); chk("R7 unaligned", rd_data, 32'd0);
    rd(16'h1008); chk("R7 alias", rd_data, 32'd0);
    rd(16'hFFFC); chk("R7 top", rd_data, 32'd0);

    cur_req = "R8";
    wr(16'h0000, 32'h11); wr(16'h0004, 32'h22); wr(16'h000C, 32'h33);
    wr(16'h1008, 32'h44); chk("R8 led kept", {24'd0, led_out}, 32'hC3);
    wr(16'h1010, 32'h0000DEAD); chk("R8 alias no pulse", {31'd0, board_rst_req}, 32'd0);
    rd(16'h0000); chk("R8 id kept", rd_data, 32'h09272011);
    rd(16'h0008); chk("R8 led read kept", rd_data, 32'hC3);

    cur_req = "R9";
    for (int i = 0; i < 20; i++) begin
      bus_rd = i[0];
      bus_addr = 16'(i % 5) << 2;
      dip_in = 8'(i * 37);
      step();
    end
    bus_rd = 1'b0;
    step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule